// File: doc/BRIEF.md
# Parallel EPROM Read Controller

This block lets synchronous logic read bytes from an asynchronous 32K x 8 parallel EPROM. The host side is a valid/ready handshake. The host offers a 15-bit address, and the block later returns the byte with a one-cycle response pulse. The memory side has an address bus, an active-low chip select, an active-low output gate and the byte-wide data bus coming from the memory.

The memory's analog timing is converted to clock cycles when the block is elaborated. Each limit is rounded up from its nanosecond value for the chosen speed grade and clock period. For each read, the block lowers the chip select and presents the address. It lowers the output gate late enough that both of the memory's access paths finish on the same clock edge, and it captures the byte on that edge. Both strobes then rise. The strobes stay high for a float gap before the next access starts.

A request can be accepted while the float gap is running. That request is held and launched on the edge where the gap ends. When nothing is waiting, the chip select stays high, which keeps the memory in standby.

Top module: `eprom_read_ctrl`

## Requirements
- R1: After reset, memCeN and memOeN are 1, rspValid is 0 and reqReady is 1.
- R2: Each response carries the byte that the memory drives at the address of the matching request. Responses come in request order.
- R3: memCeN falls and memAddr takes the request address on one edge. memOeN falls OE_START = SAMP_CYC - OE_CYC edges later. SAMP_CYC is the larger of ACC_CYC and OE_CYC. ACC_CYC is ceil(tACC/Tclk) and OE_CYC is ceil(tOE/Tclk). With the defaults (20 ns clock, 90 ns address/select access, 40 ns gate access) these are 5, 2 and 3.
- R4: memOeN is never 0 while memCeN is 1.
- R5: The data bus is captured on the edge that falls SAMP_CYC edges after memCeN fell. On that same edge both strobes rise and rspValid goes to 1 for exactly one cycle.
- R6: memAddr does not change while memCeN stays 0.
- R7: After the strobes rise, memCeN stays 1 for at least OFF_CYC = max(1, ceil(tOFF/Tclk)) cycles. This is 2 with the defaults.
- R8: A request accepted during the float gap is held. Its memCeN falls on the edge where the gap reaches OFF_CYC cycles.
- R9: memCeN stays 1 whenever no request is accepted or held.
- R10: reqReady is 0 during an access and while a request is held. reqValid and reqAddr have no effect until reqReady returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host offers a read |
| reqAddr | input | 15 | Byte address of the offered read |
| reqReady | output | 1 | The offer is taken on this edge when reqValid is 1 |
| rspValid | output | 1 | One-cycle pulse: rspData holds the byte read |
| rspData | output | 8 | Byte read from the memory |
| memAddr | output | 15 | Memory address bus |
| memCeN | output | 1 | Memory chip select, active low |
| memOeN | output | 1 | Memory output gate, active low |
| memData | input | 8 | Memory data bus |

## Verification
The memory model drives a known byte only after the address, the select and the gate have each been held for their own cycle counts. At every other time it drives a fixed wrong pattern, so sampling even one edge early shows up as wrong data. Reads are tried in three patterns:
- Isolated reads from standby, which show the launch latency straight from idle.
- Zero-gap bursts, where each request lands inside the float gap and shows the hold-then-launch path.
- Reads with random idle gaps, some offered while the block is busy with a changing junk address. These separate correct back-pressure from a controller that takes requests early.

Directed reads of the first, last and alternating-bit addresses check the full address width.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  // Per-cycle commands from the control FSM to the datapath
  typedef struct packed {
    logic loadAddr;   // take reqAddr into the memory address register
    logic ceOn;       // pull chip select low
    logic oeOn;       // pull output gate low
    logic relStrb;    // raise both strobes
    logic capture;    // register the data bus and pulse the response
  } ctlStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Address (and select) to data time in ns, per speed grade 0..4
  function automatic int gradeAccNs(input int grade);
    case (grade)
      0: return 90;
      1: return 100;
      2: return 120;
      3: return 150;
      default: return 200;
    endcase
  endfunction

  // Output gate to data time in ns
  function automatic int gradeOeNs(input int grade);
    case (grade)
      0: return 40;
      1: return 45;
      2: return 55;
      3: return 65;
      default: return 75;
    endcase
  endfunction

  // Strobe release to bus float time in ns
  function automatic int gradeOffNs(input int grade);
    case (grade)
      0: return 30;
      1: return 30;
      2: return 35;
      3: return 50;
      default: return 55;
    endcase
  endfunction

endpackage

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_pkg::*;
#(
  parameter int SAMP_CYC = 5,
  parameter int OE_START = 3,
  parameter int OFF_CYC  = 2,
  parameter int CNT_W    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  output logic       reqReady,
  output ctlStrobe_t strb
);

  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_FLOAT} rdState_t;

  rdState_t   state, nState;
  logic [CNT_W-1:0] cnt, nCnt, cntInc;
  logic       pending, nPending;
  logic       accept;

  localparam logic EARLY_OE = (OE_START == 0);

  assign reqReady = (state == ST_IDLE) || ((state == ST_FLOAT) && !pending);
  assign accept   = reqValid && reqReady;
  assign cntInc   = cnt + 1'b1;

  always_comb begin
    strb     = '0;
    nState   = state;
    nCnt     = cnt;
    nPending = pending;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          strb.loadAddr = 1'b1;
          strb.ceOn     = 1'b1;
          strb.oeOn     = EARLY_OE;
          nState        = ST_ACCESS;
          nCnt          = '0;
        end
      end
      ST_ACCESS: begin
        nCnt = cntInc;
        if (!EARLY_OE && (cntInc == CNT_W'(OE_START)))
          strb.oeOn = 1'b1;
        if (cntInc == CNT_W'(SAMP_CYC)) begin
          strb.capture = 1'b1;
          strb.relStrb = 1'b1;
          nState       = ST_FLOAT;
          nCnt         = '0;
        end
      end
      ST_FLOAT: begin
        nCnt = cntInc;
        if (cntInc == CNT_W'(OFF_CYC)) begin
          nCnt = '0;
          if (pending || accept) begin
            strb.loadAddr = accept;
            strb.ceOn     = 1'b1;
            strb.oeOn     = EARLY_OE;
            nPending      = 1'b0;
            nState        = ST_ACCESS;
          end else begin
            nState = ST_IDLE;
          end
        end else if (accept) begin
          strb.loadAddr = 1'b1;
          nPending      = 1'b1;
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      state   <= nState;
      cnt     <= nCnt;
      pending <= nPending;
    end
  end

endmodule

// File: rtl/eprom_rd_dpath.sv
module eprom_rd_dpath
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] rspData,
  output logic              rspValid
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      memAddr  <= '0;
      memCeN   <= 1'b1;
      memOeN   <= 1'b1;
      rspData  <= '0;
      rspValid <= 1'b0;
    end else begin
      if (strb.loadAddr) memAddr <= reqAddr;
      if (strb.ceOn)         memCeN <= 1'b0;
      else if (strb.relStrb) memCeN <= 1'b1;
      if (strb.oeOn)         memOeN <= 1'b0;
      else if (strb.relStrb) memOeN <= 1'b1;
      if (strb.capture) rspData <= memData;
      rspValid <= strb.capture;
    end
  end

endmodule

// File: rtl/eprom_read_ctrl.sv
module eprom_read_ctrl
  import eprom_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int SPEED_GRADE   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  input  logic [DATA_W-1:0] memData
);

  localparam int ACC_CYC  = ceilDiv(gradeAccNs(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int OE_CYC   = maxInt(1, ceilDiv(gradeOeNs(SPEED_GRADE), CLK_PERIOD_NS));
  localparam int OFF_CYC  = maxInt(1, ceilDiv(gradeOffNs(SPEED_GRADE), CLK_PERIOD_NS));
  localparam int SAMP_CYC = maxInt(ACC_CYC, OE_CYC);
  localparam int OE_START = SAMP_CYC - OE_CYC;
  localparam int CNT_W    = $clog2(maxInt(SAMP_CYC, OFF_CYC) + 1);

  ctlStrobe_t strb;

  eprom_rd_ctrl #(
    .SAMP_CYC(SAMP_CYC), .OE_START(OE_START), .OFF_CYC(OFF_CYC), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady), .strb(strb)
  );

  eprom_rd_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .reqAddr(reqAddr), .memData(memData),
    .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN),
    .rspData(rspData), .rspValid(rspValid)
  );

endmodule

// File: rtl/eprom_read_sva.sv
module eprom_read_sva
  import eprom_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int CLK_PERIOD_NS = 20,
  parameter int SPEED_GRADE   = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memOeN
);

  localparam int ACC_CYC  = ceilDiv(gradeAccNs(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int OE_CYC   = maxInt(1, ceilDiv(gradeOeNs(SPEED_GRADE), CLK_PERIOD_NS));
  localparam int OFF_CYC  = maxInt(1, ceilDiv(gradeOffNs(SPEED_GRADE), CLK_PERIOD_NS));
  localparam int SAMP_CYC = maxInt(ACC_CYC, OE_CYC);

  logic [15:0] ceLowCnt, oeLowCnt, ceHighCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ceLowCnt  <= '0;
      oeLowCnt  <= '0;
      ceHighCnt <= 16'(OFF_CYC);
    end else begin
      ceLowCnt  <= memCeN ? '0 : ceLowCnt + 1'b1;
      oeLowCnt  <= memOeN ? '0 : oeLowCnt + 1'b1;
      if (!memCeN) ceHighCnt <= '0;
      else if (ceHighCnt != 16'hFFFF) ceHighCnt <= ceHighCnt + 1'b1;
    end
  end

  p_oe_inside_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !memOeN |-> !memCeN);

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  p_capture_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> ($rose(memCeN) && ceLowCnt == 16'(SAMP_CYC)));

  p_oe_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> (oeLowCnt == 16'(OE_CYC)));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |=> !rspValid);

  p_float_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(memCeN) |-> (ceHighCnt >= 16'(OFF_CYC)));

  p_busy_backpressure_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !memCeN |-> !reqReady);

endmodule

bind eprom_read_ctrl eprom_read_sva #(
  .ADDR_W(ADDR_W), .CLK_PERIOD_NS(CLK_PERIOD_NS), .SPEED_GRADE(SPEED_GRADE)
) u_sva (
  .clk(clk), .rst_n(rst_n), .reqReady(reqReady), .rspValid(rspValid),
  .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN)
);

// File: tb/tb_eprom_read_ctrl.sv
module tb_eprom_read_ctrl;

  // Expected cycle counts from the default grade (90/40/30 ns) and a 20 ns clock
  localparam int CLK_NS   = 20;
  localparam int ACC      = (90 + CLK_NS - 1) / CLK_NS;
  localparam int OEC      = (40 + CLK_NS - 1) / CLK_NS;
  localparam int OFF      = (30 + CLK_NS - 1) / CLK_NS;
  localparam int SAMP     = (ACC > OEC) ? ACC : OEC;
  localparam int OE_START = SAMP - OEC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [14:0] reqAddr = '0;
  logic        reqReady, rspValid;
  logic [7:0]  rspData, memData;
  logic [14:0] memAddr;
  logic        memCeN, memOeN;

  always #10 clk = ~clk;

  eprom_read_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .rspValid(rspValid), .rspData(rspData),
    .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN), .memData(memData)
  );

  int nChk = 0, nErr = 0, nReq = 0, nRsp = 0, cycles = 0;

  function automatic logic [7:0] romByte(input logic [14:0] a);
    return (a[7:0] ^ {a[14:8], 1'b0}) + 8'h3C;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  endtask

  // Memory model: a valid byte only once every path has had its full time
  int ceLowM = 0, oeLowM = 0, addrAgeM = 0;
  logic [14:0] lastAddrM = '0;
  logic modelOk;
  always @(negedge clk) begin
    ceLowM   = memCeN ? 0 : ceLowM + 1;
    oeLowM   = memOeN ? 0 : oeLowM + 1;
    addrAgeM = (memAddr == lastAddrM) ? addrAgeM + 1 : 1;
    lastAddrM = memAddr;
  end
  assign modelOk = (ceLowM >= ACC) && (oeLowM >= OEC) && (addrAgeM >= ACC);
  assign memData = (modelOk && !memCeN && !memOeN) ? romByte(memAddr) : 8'hEE;

  // Monitor
  logic [14:0] addrQ[$];
  int          holdQ[$];
  logic [14:0] rspQ[$];
  int  ceLowRun = 0, highRun = OFF;
  logic prevCe = 1'b1, prevOe = 1'b1, prevRsp = 1'b0;
  logic [14:0] prevAddr = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      ceLowRun = 0; highRun = OFF; prevCe = 1'b1; prevOe = 1'b1; prevRsp = 1'b0;
    end else begin
      if (!memOeN && memCeN) check(1'b0, "R4 gate low with select high", 1, 0);
      if (!prevCe && !memCeN)
        if (memAddr != prevAddr) check(1'b0, "R6 address moved during access", memAddr, prevAddr);
      if (prevCe && !memCeN) begin
        if (addrQ.size() == 0) begin
          check(1'b0, "R9 select fell with no request", 0, 1);
        end else begin
          logic [14:0] a;
          int h;
          a = addrQ.pop_front();
          h = holdQ.pop_front();
          check(memAddr == a, "R3/R10 address at select fall", memAddr, a);
          check(highRun == h, "R7/R8 idle cycles before select fall", highRun, h);
          rspQ.push_back(a);
        end
      end
      if (prevOe && !memOeN)
        check(ceLowRun == OE_START, "R3 gate delay after select", ceLowRun, OE_START);
      if (rspValid) begin
        nRsp++;
        check(!prevRsp, "R5 response pulse width", 2, 1);
        check(ceLowRun == SAMP && memCeN && memOeN, "R5 capture edge", ceLowRun, SAMP);
        if (rspQ.size() == 0) check(1'b0, "R2 response with no access", 1, 0);
        else begin
          logic [14:0] ra;
          ra = rspQ.pop_front();
          check(rspData == romByte(ra), "R2 data byte", rspData, romByte(ra));
        end
      end
      ceLowRun = memCeN ? 0 : ceLowRun + 1;
      highRun  = memCeN ? ((highRun < 100000) ? highRun + 1 : highRun) : 0;
      prevCe = memCeN; prevOe = memOeN; prevRsp = rspValid; prevAddr = memAddr;
    end
  end

  // Driver: called at negedge+1
  task automatic issue(input logic [14:0] a, input bit scramble);
    reqValid = 1'b1;
    reqAddr  = scramble ? 15'($urandom) : a;
    while (!reqReady) begin
      @(negedge clk); #1;
      if (scramble) reqAddr = 15'($urandom);
    end
    reqAddr = a;
    addrQ.push_back(a);
    holdQ.push_back((highRun > OFF) ? highRun : OFF);
    nReq++;
    @(negedge clk); #1;
    reqValid = 1'b0;
    reqAddr  = 15'($urandom);
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "watchdog expired", cycles, 150000);
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(memCeN && memOeN && !rspValid && reqReady, "R1 reset state",
          {memCeN, memOeN, rspValid, reqReady}, 4'b1101);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    check(memCeN && memOeN && !rspValid && reqReady, "R1 state after reset",
          {memCeN, memOeN, rspValid, reqReady}, 4'b1101);

    // Directed isolated reads: first, last, alternating bits
    issue(15'h0000, 1'b0); idleCycles(12);
    issue(15'h7FFF, 1'b0); idleCycles(12);
    issue(15'h5555, 1'b0); idleCycles(12);
    check(memCeN && memOeN, "R9 standby while idle", {memCeN, memOeN}, 2'b11);

    // Zero-gap burst: later requests land in the float gap (R8)
    issue(15'h2AAA, 1'b0);
    issue(15'h0001, 1'b0);
    issue(15'h4000, 1'b1);
    issue(15'h1234, 1'b1);
    idleCycles(15);
    check(memCeN && memOeN, "R9 standby after burst", {memCeN, memOeN}, 2'b11);

    // Random mix, junk addresses while busy (R10)
    for (int k = 0; k < 300; k++) begin
      issue(15'($urandom), 1'($urandom));
      idleCycles(int'($urandom % 4));
    end
    idleCycles(20);
    check(memCeN && memOeN, "R9 standby at end", {memCeN, memOeN}, 2'b11);
    check(nRsp == nReq && addrQ.size() == 0 && rspQ.size() == 0,
          "R2 every request answered", nRsp, nReq);
    finishRun();
  end

endmodule